// File: doc/BRIEF.md
# I2C Bus Event Status Flags

This block keeps the event and status flags of an I2C controller. It watches the raw SDA and SCL levels through a two-stage synchronizer and recognises START conditions (SDA falls while SCL is high) and STOP conditions (SDA rises while SCL is high). It also takes single-cycle strobes from the controller's sequencer for a received NACK and for lost arbitration. From these inputs it keeps four sticky flags, a bus-busy bit and an SCL-low bit.

Software clears flags by writing ones: a write strobe together with a mask clears every flag whose mask bit is one. Some flags also clear themselves when the opposite bus condition is seen. The flags that belong to the end of a transfer are wiped by the next START, and the START flag is wiped by the next STOP. The interrupt line is high whenever any flag is set and its enable bit is also set. A software reset input clears all flags and the busy bit, and it holds them cleared for as long as it stays asserted.

Top module: `i2c_evt_status`

## Requirements
- R1: After rst_ni is released, flags_o is 4'b0000, busy_o is 0, scl_low_o is 0 and irq_o is 0.
- R2: A falling SDA edge while SCL is high sets the START flag, flags_o[0]. The flag appears on the third rising clock edge after the input change, because of two synchronizer stages and one flag register. SDA changes made while SCL is low set no flag.
- R3: A rising SDA edge while SCL is high sets the STOP flag, flags_o[1], and clears the START flag in the same update. The NACK and arbitration-lost flags are unchanged.
- R4: A START clears the STOP flag and the NACK flag, flags_o[2]. The arbitration-lost flag, flags_o[3], is not cleared by any bus condition.
- R5: A one-cycle pulse on nack_evt_i sets flags_o[2] at the next clock edge. A one-cycle pulse on al_evt_i sets flags_o[3] at the next clock edge.
- R6: When clr_we_i is high, each flag whose bit in clr_mask_i is 1 reads 0 after the next edge. Flags whose mask bit is 0 keep their value. When clr_we_i is low, the mask has no effect.
- R7: If a set event and a software clear reach the same flag in the same cycle, the flag ends up set.
- R8: busy_o rises with the START flag update and falls with the STOP flag update.
- R9: While soft_rst_i is high, all flags and busy_o are 0 from the next edge on, and bus conditions and event strobes set nothing.
- R10: scl_low_o is 1 when busy_o is 1 and the synchronized SCL is low. It follows a change on scl_i after two clock edges.
- R11: irq_o is the OR over all flags of flags_o[i] AND irq_en_i[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Software reset, holds flags and busy cleared |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| nack_evt_i | input | 1 | NACK-received strobe from the sequencer |
| al_evt_i | input | 1 | Arbitration-lost strobe from the sequencer |
| clr_we_i | input | 1 | Write-one-to-clear strobe |
| clr_mask_i | input | 4 | Clear mask: [0] START, [1] STOP, [2] NACK, [3] arbitration lost |
| irq_en_i | input | 4 | Per-flag interrupt enable, same bit order |
| flags_o | output | 4 | Flag vector, same bit order |
| busy_o | output | 1 | Bus busy |
| scl_low_o | output | 1 | SCL held low during a transfer |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench sweeps all 16 clear masks against a known flag pattern, and all 16 enable patterns against two flag patterns. A wrong mask decode, or an interrupt OR that ignores its enables, therefore shows up as a wrong bit.

The bench toggles SDA while SCL is low and checks that no flag is set. A detector that ignored the SCL qualification would report false STARTs here. The bench also samples the START flag one cycle early, so a missing or extra synchronizer stage shows up.

Several cases target the priority and clearing rules:
- A clear that lands in the same cycle as a set would leave the flag low in a design that gives the clear priority.
- A repeated START must remove the NACK and STOP flags while keeping the arbitration-lost flag.
- A STOP must remove the START flag.
- Bus conditions seen while the software reset is held must leave everything clear.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned SYNC_STAGES = 2;
  // bit positions inside the flag vector
  localparam int unsigned FLG_STT  = 0;
  localparam int unsigned FLG_STP  = 1;
  localparam int unsigned FLG_NACK = 2;
  localparam int unsigned FLG_AL   = 3;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {(STAGES*W){RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic start_o,
  output logic stop_o
);
  logic sda_q, scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
    end
  end

  // SDA edge is only a bus condition when SCL is high before and after
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] acl_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // priority: soft reset > set > (sw clear | auto clear) > hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q[g] <= 1'b0;
      else if (srst_i)               q[g] <= 1'b0;
      else if (set_i[g])             q[g] <= 1'b1;
      else if (clr_i[g] || acl_i[g]) q[g] <= 1'b0;
    end

    a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_i && set_i[g]) |=> q[g]);
    a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_i && !set_i[g] && clr_i[g]) |=> !q[g]);
    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_i && !set_i[g] && !clr_i[g] && !acl_i[g]) |=> q[g] == $past(q[g]));
  end

  assign q_o = q;
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_evt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 soft_rst_i,
  input  logic                 sda_i,
  input  logic                 scl_i,
  input  logic                 nack_evt_i,
  input  logic                 al_evt_i,
  input  logic                 clr_we_i,
  input  logic [NUM_FLAGS-1:0] clr_mask_i,
  input  logic [NUM_FLAGS-1:0] irq_en_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 busy_o,
  output logic                 scl_low_o,
  output logic                 irq_o
);
  logic      sda_s, scl_s;
  logic      start_det, stop_det;
  logic      busy_q;
  flag_vec_t set_vec, acl_vec, clr_vec, flags;

  i2c_line_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sda_i, scl_i}),
    .q_o   ({sda_s, scl_s})
  );

  i2c_cond_detect u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sda_i  (sda_s),
    .scl_i  (scl_s),
    .start_o(start_det),
    .stop_o (stop_det)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_STT]  = start_det;
    set_vec[FLG_STP]  = stop_det;
    set_vec[FLG_NACK] = nack_evt_i;
    set_vec[FLG_AL]   = al_evt_i;
    // opposite bus condition wipes the flag
    acl_vec           = '0;
    acl_vec[FLG_STT]  = stop_det;
    acl_vec[FLG_STP]  = start_det;
    acl_vec[FLG_NACK] = start_det;
    clr_vec           = clr_we_i ? clr_mask_i : '0;
  end

  i2c_flag_bank #(.N(NUM_FLAGS)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .srst_i(soft_rst_i),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .acl_i (acl_vec),
    .q_o   (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_q <= 1'b0;
    else if (soft_rst_i) busy_q <= 1'b0;
    else if (start_det)  busy_q <= 1'b1;
    else if (stop_det)   busy_q <= 1'b0;
  end

  assign flags_o   = flags;
  assign busy_o    = busy_q;
  assign scl_low_o = busy_q & ~scl_s;
  assign irq_o     = |(flags & irq_en_i);

  a_r8_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && !soft_rst_i) |=> busy_o);
  a_r8_busy_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det || soft_rst_i) |=> !busy_o);
  a_r3_stop_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && !soft_rst_i) |=> (flags_o[FLG_STP] && !flags_o[FLG_STT]));
  a_r4_start_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && !soft_rst_i && !nack_evt_i) |=> (!flags_o[FLG_STP] && !flags_o[FLG_NACK]));
  a_r2_stt_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && !soft_rst_i) |=> flags_o[FLG_STT]);
  a_r9_soft_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (flags_o == '0 && !busy_o));
  a_r10_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_low_o |-> busy_o);
endmodule

// File: tb/sim_i2c_evt_status.sv
module sim_i2c_evt_status;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst = 1'b0;
  logic       sda = 1'b1, scl = 1'b1;
  logic       nack_evt = 1'b0, al_evt = 1'b0;
  logic       clr_we = 1'b0;
  logic [3:0] clr_mask = '0, irq_en = '0;
  logic [3:0] flags;
  logic       busy, scl_low, irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_evt_status u0 (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst),
    .sda_i(sda), .scl_i(scl), .nack_evt_i(nack_evt), .al_evt_i(al_evt),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask), .irq_en_i(irq_en),
    .flags_o(flags), .busy_o(busy), .scl_low_o(scl_low), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lines(input logic d, input logic c);
    sda = d; scl = c;
    step(1);
  endtask

  task automatic do_start();
    lines(sda, 1'b0); lines(1'b1, 1'b0); lines(1'b1, 1'b1); lines(1'b0, 1'b1);
    step(2);
  endtask

  task automatic do_stop();
    lines(sda, 1'b0); lines(1'b0, 1'b0); lines(1'b0, 1'b1); lines(1'b1, 1'b1);
    step(2);
  endtask

  task automatic pulse(input logic nk, input logic al, input logic we, input logic [3:0] m);
    nack_evt = nk; al_evt = al; clr_we = we; clr_mask = m;
    step(1);
    nack_evt = 0; al_evt = 0; clr_we = 0; clr_mask = '0;
  endtask

  task automatic soft_pulse();
    soft_rst = 1; step(1); soft_rst = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      report();
    end
  end

  initial begin
    step(2);
    rst_ni = 1;
    step(1);
    // R1 reset state
    chk("R1 flags", flags, 4'b0000);
    chk("R1 busy/scl_low/irq", {1'b0, busy, scl_low, irq}, 4'b0000);

    // R2 SDA toggles with SCL low: no condition
    lines(1, 0); lines(0, 0); lines(1, 0); lines(0, 0); lines(1, 0);
    step(3);
    chk("R2 no event with scl low", flags, 4'b0000);
    chk("R8 idle busy", {3'b0, busy}, 4'b0000);

    // R2 START latency
    lines(1, 1); lines(0, 1);
    step(1);
    chk("R2 start not yet", flags, 4'b0000);
    step(1);
    chk("R2 start flag", flags, 4'b0001);
    chk("R8 busy after start", {3'b0, busy}, 4'b0001);

    // R10 SCL low while busy, two-edge latency
    lines(0, 0);
    chk("R10 scl_low latency", {3'b0, scl_low}, 4'b0000);
    step(1);
    chk("R10 scl_low set", {3'b0, scl_low}, 4'b0001);
    lines(0, 1); step(1);
    chk("R10 scl_low released", {3'b0, scl_low}, 4'b0000);

    // R5 sequencer strobes
    pulse(1, 0, 0, 4'b0000);
    chk("R5 nack flag", flags, 4'b0101);
    pulse(0, 1, 0, 4'b0000);
    chk("R5 al flag", flags, 4'b1101);

    // R6 mask with clr_we low is ignored
    clr_mask = 4'b1111; step(2); clr_mask = '0;
    chk("R6 mask without strobe", flags, 4'b1101);

    // R3 STOP
    do_stop();
    chk("R3 stop flags", flags, 4'b1110);
    chk("R8 busy after stop", {3'b0, busy}, 4'b0000);
    lines(1, 0); step(1);
    chk("R10 scl low while idle", {3'b0, scl_low}, 4'b0000);
    lines(1, 1);

    // R4 repeated START clears STOP and NACK, keeps AL
    do_start();
    chk("R4 start clears stp/nack", flags, 4'b1001);

    // R7 set beats clear in same cycle
    pulse(1, 0, 1, 4'b0100);
    chk("R7 nack set beats clear", flags, 4'b1101);
    pulse(0, 1, 1, 4'b1111);
    chk("R7 al set beats clear", flags, 4'b1000);

    // R9 soft reset holds everything clear
    soft_rst = 1; step(1);
    chk("R9 soft clear", {busy, 3'b0} | flags, 4'b0000);
    do_start();
    pulse(1, 1, 0, 4'b0000);
    chk("R9 events ignored", {busy, 3'b0} | flags, 4'b0000);
    soft_rst = 0;

    // R6 exhaustive clear masks on pattern 1101
    for (int m = 0; m < 16; m++) begin
      soft_pulse();
      do_start();
      pulse(1, 1, 0, 4'b0000);
      pulse(0, 0, 1, 4'(m));
      chk($sformatf("R6 mask %0d", m), flags, 4'b1101 & ~4'(m));
    end

    // R11 exhaustive enables on two flag patterns
    soft_pulse();
    do_start();
    pulse(1, 1, 0, 4'b0000);
    for (int e = 0; e < 16; e++) begin
      irq_en = 4'(e); step(1);
      chk($sformatf("R11 en %0d pat 1101", e), {3'b0, irq}, {3'b0, |(4'b1101 & 4'(e))});
    end
    do_stop();
    for (int e = 0; e < 16; e++) begin
      irq_en = 4'(e); step(1);
      chk($sformatf("R11 en %0d pat 1110", e), {3'b0, irq}, {3'b0, |(4'b1110 & 4'(e))});
    end

    finished = 1;
    report();
  end
endmodule